// File: doc/BRIEF.md
# Memory-Mapped Distance Sensor Port

This block connects a distance sensor to a processor bus through one 32-bit word of three registers. Bytes 0 and 1 hold the most recent distance reading in centimetres. Byte 2 holds status. Byte 3 is a command byte. Software drives the sensor only by writing a command code. The port acts on that code one clock later and then returns the command byte to zero.

Readings arrive on the sensor side as a value with a level strobe. The strobe is brought into the bus clock through a synchronizer and turned into a single-cycle capture pulse. The value must stay stable while the strobe is high.

Two acquisition modes decide whether a reading may replace the stored value. In continuous mode every reading is copied. In hold mode the first reading raises a new-data flag. Later readings are dropped until software clears that flag. A two-bit error code from the sensor is also synchronized and shown in status while the sensor is on.

Top module: `dist_sensor_port`

## Requirements
- R1: After reset every field of the register word reads zero: sensor off, hold mode, no new data, error 0, distance 0 and command 0.
- R2: The word answers only at byte address 0x100 (bits 11:2 equal 0x040). It carries the distance in bits 15:0, status in bits 23:16 and the command in bits 31:24. Any other address reads 0, and writes to it change nothing.
- R3: A byte written to the command lane (write with enable bit 3) reads back for exactly one cycle and is 0 after the next clock edge. Codes 0 and 5 to 255 change no other field.
- R4: Code 4 sets status bit 0 (sensor on) and code 3 clears it. The change is visible after the clock edge that follows the write edge.
- R5: Code 1 selects continuous mode (status bit 2 = 1) and code 2 selects hold mode (status bit 2 = 0), with the same one-edge latency as R4.
- R6: A reading whose strobe is first sampled high at clock edge T is visible in bits 15:0 after edge T+2. Each rising strobe is captured at most once.
- R7: In hold mode with the sensor on, an accepted reading sets status bit 1 (new data). While that bit is 1, further readings leave the distance unchanged.
- R8: Writing the status lane with bit 17 = 0 clears the new-data bit. Writing bit 17 = 1 has no effect. All other status bits and both distance bytes ignore bus writes.
- R9: In continuous mode with the sensor on, every reading replaces the distance and the new-data bit keeps its value.
- R10: While the sensor is off, readings are ignored and status bits 7:6 read 0. Command 3 also clears the new-data bit.
- R11: While the sensor is on, status bits 7:6 show the sensor error code that was sampled at the edge before the most recent one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| sns_vld | input | 1 | Sensor reading strobe, held high per reading |
| sns_dist | input | 16 | Sensor distance value in centimetres |
| sns_err | input | 2 | Sensor error code |

## Verification
Each result has its own latency. A command byte is readable right after its write edge, and its effect appears one edge later. A distance appears three edges after the strobe is first driven high. An error code appears two edges after it changes. The bench keeps a behavioural model with queues of past strobe and error samples. It advances the model on each rising edge and compares the whole read word 2 ns later, so every result is checked in the cycle it becomes due. Directed checks sample at falling edges that were counted out from these latencies, including the one-cycle window in which a command can be read back.

// File: rtl/dsp_pkg.sv
`timescale 1ns/1ps
package dsp_pkg;
   typedef enum logic [7:0] {
      CMD_IDLE = 8'd0,
      CMD_CONT = 8'd1,
      CMD_HOLD = 8'd2,
      CMD_OFF  = 8'd3,
      CMD_ON   = 8'd4
   } cmd_e;

   localparam int STAT_ON     = 0;
   localparam int STAT_NEW    = 1;
   localparam int STAT_MODE   = 2;
   localparam int STAT_ERR_LO = 6;

   localparam int LANE_STAT = 2;
   localparam int LANE_CMD  = 3;
endpackage

// File: rtl/dsp_sync.sv
`timescale 1ns/1ps
module dsp_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dsp_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("dsp_sync: W must be positive");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[0] <= '0;
      else        st[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st[i] <= '0;
         else        st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/dsp_edge.sv
`timescale 1ns/1ps
module dsp_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic pulse
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign pulse = lvl & ~prev_q;

   // R6
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);
endmodule

// File: rtl/dsp_regs.sv
`timescale 1ns/1ps
module dsp_regs
   import dsp_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_wr,
   input  logic [7:0]    cmd_wdata,
   input  logic          nd_clr,
   input  logic          smp_pulse,
   input  logic [DW-1:0] smp_data,
   output logic [DW-1:0] data_q,
   output logic [7:0]    cmd_q,
   output logic          on_q,
   output logic          mode_q,
   output logic          nd_q
);
   logic accept;

   always_comb begin
      accept = on_q & smp_pulse & (mode_q | ~nd_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         cmd_q  <= CMD_IDLE;
         on_q   <= 1'b0;
         mode_q <= 1'b0;
         nd_q   <= 1'b0;
      end else begin
         cmd_q <= cmd_wr ? cmd_wdata : CMD_IDLE;
         if (accept) data_q <= smp_data;
         case (cmd_q)
            CMD_CONT: mode_q <= 1'b1;
            CMD_HOLD: mode_q <= 1'b0;
            CMD_OFF:  on_q   <= 1'b0;
            CMD_ON:   on_q   <= 1'b1;
            default:  ;
         endcase
         if (cmd_q == CMD_OFF)        nd_q <= 1'b0;
         else if (accept && !mode_q)  nd_q <= 1'b1;
         else if (nd_clr)             nd_q <= 1'b0;
      end
   end

   // R3
   cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q != CMD_IDLE && !cmd_wr) |=> (cmd_q == CMD_IDLE));

   // R7
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (on_q && !mode_q && nd_q) |=> $stable(data_q));

   // R8
   nd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nd_clr && nd_q) |=> !nd_q);

   // R9
   cont_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (on_q && mode_q && smp_pulse) |=> (data_q == $past(smp_data)));

   // R10
   off_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !on_q |=> $stable(data_q));
endmodule

// File: rtl/dist_sensor_port.sv
`timescale 1ns/1ps
module dist_sensor_port
   import dsp_pkg::*;
#(
   parameter int                DATA_W      = 16,
   parameter int                ADDR_W      = 12,
   parameter logic [ADDR_W-1:0] BASE_ADDR   = 'h100,
   parameter int                SYNC_STAGES = 2,
   parameter int                ERR_W       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [3:0]        bus_be,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              sns_vld,
   input  logic [DATA_W-1:0] sns_dist,
   input  logic [ERR_W-1:0]  sns_err
);
   localparam int WORD_LSB = 2;
   localparam int STAT_LSB = 8 * LANE_STAT;
   localparam int CMD_LSB  = 8 * LANE_CMD;

   if (DATA_W < 1 || DATA_W > 16) begin : g_bad_data
      $error("dist_sensor_port: DATA_W must be 1..16");
   end
   if (ERR_W < 1 || ERR_W > 2) begin : g_bad_err
      $error("dist_sensor_port: ERR_W must be 1..2");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("dist_sensor_port: ADDR_W too small");
   end
   if (BASE_ADDR[1:0] != 2'b00) begin : g_bad_base
      $error("dist_sensor_port: BASE_ADDR must be word aligned");
   end

   logic              hit;
   logic              cmd_wr;
   logic              nd_clr;
   logic              vld_s;
   logic              smp_pulse;
   logic [ERR_W-1:0]  err_s;
   logic [DATA_W-1:0] data_q;
   logic [7:0]        cmd_q;
   logic              on_q, mode_q, nd_q;
   logic [7:0]        stat;
   logic [15:0]       data_ext;
   logic              unused_bits;

   assign hit    = (bus_addr[ADDR_W-1:WORD_LSB] == BASE_ADDR[ADDR_W-1:WORD_LSB]);
   assign cmd_wr = bus_wr & hit & bus_be[LANE_CMD];
   assign nd_clr = bus_wr & hit & bus_be[LANE_STAT] & ~bus_wdata[STAT_LSB + STAT_NEW];
   assign unused_bits = ^{bus_be[1:0], bus_addr[WORD_LSB-1:0], bus_wdata[23:18],
                          bus_wdata[16], bus_wdata[15:0]};

   dsp_sync #(.W(1), .STAGES(SYNC_STAGES)) u_vld_sync (
      .clk(clk), .rst_n(rst_n), .d(sns_vld), .q(vld_s));

   dsp_sync #(.W(ERR_W), .STAGES(SYNC_STAGES)) u_err_sync (
      .clk(clk), .rst_n(rst_n), .d(sns_err), .q(err_s));

   dsp_edge u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(vld_s), .pulse(smp_pulse));

   dsp_regs #(.DW(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cmd_wr(cmd_wr), .cmd_wdata(bus_wdata[CMD_LSB +: 8]),
      .nd_clr(nd_clr), .smp_pulse(smp_pulse), .smp_data(sns_dist),
      .data_q(data_q), .cmd_q(cmd_q), .on_q(on_q), .mode_q(mode_q), .nd_q(nd_q));

   always_comb begin
      stat = '0;
      stat[STAT_ON]   = on_q;
      stat[STAT_NEW]  = nd_q;
      stat[STAT_MODE] = mode_q;
      stat[STAT_ERR_LO +: ERR_W] = on_q ? err_s : '0;
      data_ext = '0;
      data_ext[DATA_W-1:0] = data_q;
      bus_rdata = hit ? {cmd_q, stat, data_ext} : '0;
   end

   // R4
   on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_ON) |=> on_q);

   // R5
   cont_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_CONT) |=> mode_q);

   // R10
   off_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_OFF) |=> (bus_rdata[STAT_LSB + STAT_ERR_LO +: ERR_W] == '0 && !nd_q));
endmodule

// File: tb/test_dist_sensor_port.sv
`timescale 1ns/1ps
module test_dist_sensor_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = 12'h100;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_be = 4'h0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sns_vld = 1'b0;
   logic [15:0] sns_dist = '0;
   logic [1:0]  sns_err = '0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   dist_sensor_port i_dist_sensor_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sns_vld(sns_vld), .sns_dist(sns_dist), .sns_err(sns_err));

   // reference model state
   logic [15:0] m_data;
   logic [7:0]  m_cmd;
   logic        m_on, m_mode, m_nd;
   logic        vh[$];
   logic [1:0]  eh[$];

   function automatic logic [31:0] exp_word(logic [11:0] a);
      logic [7:0] st;
      if (a[11:2] != 10'h040) return 32'h0;
      st = {(m_on ? eh[1] : 2'b00), 3'b000, m_mode, m_nd, m_on};
      return {m_cmd, st, m_data};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_data = '0; m_cmd = '0; m_on = 0; m_mode = 0; m_nd = 0;
         vh = '{1'b0, 1'b0, 1'b0};
         eh = '{2'b00, 2'b00};
      end else begin
         logic pulse, acc, hit, clr, nd_n;
         pulse = vh[1] && !vh[2];
         acc   = m_on && pulse && (m_mode || !m_nd);
         hit   = (bus_addr[11:2] == 10'h040);
         clr   = bus_wr && hit && bus_be[2] && !bus_wdata[17];
         nd_n  = m_nd;
         if (m_cmd == 8'd3)         nd_n = 1'b0;
         else if (acc && !m_mode)   nd_n = 1'b1;
         else if (clr)              nd_n = 1'b0;
         if (acc) m_data = sns_dist;
         case (m_cmd)
            8'd1: m_mode = 1'b1;
            8'd2: m_mode = 1'b0;
            8'd3: m_on = 1'b0;
            8'd4: m_on = 1'b1;
            default: ;
         endcase
         m_cmd = (bus_wr && hit && bus_be[3]) ? bus_wdata[31:24] : 8'h00;
         m_nd  = nd_n;
         vh.push_front(sns_vld); void'(vh.pop_back());
         eh.push_front(sns_err); void'(eh.pop_back());
      end
      #2;
      if (rst_n) begin
         checks++;
         if (bus_rdata !== exp_word(bus_addr)) begin
            errors++;
            $display("FAIL R2 per-cycle model @%0t addr %h: act %h exp %h",
                     $time, bus_addr, bus_rdata, exp_word(bus_addr));
         end
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: act %h exp %h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [3:0] be, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = 4'h0; bus_addr = 12'h100;
   endtask

   task automatic sample(logic [15:0] v);
      @(negedge clk);
      sns_dist = v; sns_vld = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic sample_end();
      sns_vld = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset word", bus_rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", bus_rdata, 32'h0);

      wr(12'h100, 4'h8, 32'h0400_0000);
      chk("R3 cmd visible one cycle", bus_rdata, 32'h0400_0000);
      @(negedge clk);
      chk("R4 on, R3 cmd cleared", bus_rdata, 32'h0001_0000);

      sample(16'h0123);
      chk("R6 latency, R7 new data set", bus_rdata, 32'h0003_0123);
      sample_end();
      sample(16'h0456);
      chk("R7 hold keeps value", bus_rdata[15:0], 16'h0123);
      sample_end();

      wr(12'h100, 4'h4, 32'h0002_0000);
      chk("R8 writing 1 keeps flag", bus_rdata, 32'h0003_0123);
      wr(12'h100, 4'h3, 32'h00FF_FFFF);
      chk("R8 distance read-only", bus_rdata, 32'h0003_0123);
      wr(12'h100, 4'h4, 32'h0000_0000);
      chk("R8 flag cleared", bus_rdata, 32'h0001_0123);
      sample(16'h0789);
      chk("R7 accept after clear", bus_rdata, 32'h0003_0789);
      sample_end();

      wr(12'h100, 4'h8, 32'h0100_0000);
      @(negedge clk);
      chk("R5 continuous mode", bus_rdata, 32'h0007_0789);
      sample(16'h0AAA);
      chk("R9 copy, flag kept", bus_rdata, 32'h0007_0AAA);
      sample_end();
      sample(16'h0BBB);
      chk("R9 second copy", bus_rdata, 32'h0007_0BBB);
      sample_end();

      wr(12'h100, 4'h8, 32'h0900_0000);
      chk("R3 unknown code readable", bus_rdata, 32'h0907_0BBB);
      @(negedge clk);
      chk("R3 unknown code no effect", bus_rdata, 32'h0007_0BBB);

      sns_err = 2'b10;
      repeat (2) @(negedge clk);
      chk("R11 error code shown", bus_rdata, 32'h0087_0BBB);

      wr(12'h100, 4'h8, 32'h0300_0000);
      @(negedge clk);
      chk("R4 off, R10 err and flag zero", bus_rdata, 32'h0004_0BBB);
      sample(16'h0CCC);
      chk("R10 off ignores reading", bus_rdata, 32'h0004_0BBB);
      sample_end();

      wr(12'h100, 4'h8, 32'h0200_0000);
      @(negedge clk);
      chk("R5 hold mode", bus_rdata, 32'h0000_0BBB);

      bus_addr = 12'h104;
      @(negedge clk);
      chk("R2 miss reads zero", bus_rdata, 32'h0);
      bus_addr = 12'h100;
      wr(12'h104, 4'hF, 32'h0400_0000);
      @(negedge clk);
      chk("R2 miss write ignored", bus_rdata, 32'h0000_0BBB);

      sns_err = 2'b00;
      repeat (4) @(negedge clk);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: act running exp finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule